// File: doc/BRIEF.md
# Selectable-Rate Interval Clock

This block is a periodic interrupt source for a small processor I/O bus. Software first picks one of four tick rates by writing a 2-bit code with a data-out strobe. A start pulse then arms a busy/done handshake, and a clear pulse stops everything. A prescaler divides the system clock down to the selected rate. Each tick that arrives while busy is set retires busy and raises done. Done, gated by an interrupt-disable mask, drives the interrupt request.

The timebase runs freely once started. Later start pulses only re-arm the flags and leave the tick phase alone. Only a clear pulse or reset stops the timebase. A rate write while the timebase is running restarts the prescaler for the new rate. The rate for code 0 follows the mains line: a configuration pin picks 50 Hz or 60 Hz. The system clock frequency is a parameter, and every reload value is derived from it at elaboration.

Top module: `interval_clock`

## Requirements
- R1: When `dout_stb` is high at an edge, `rate_sel` takes `acc_in[1:0]` on the following cycle. All other bits of `acc_in` have no effect.
- R2: Once running, `tick` is high for one cycle out of every SYS_HZ/rate cycles (integer division). The rate is 10 Hz for code 1, 100 Hz for code 2 and 1000 Hz for code 3.
- R3: For code 0 the rate is 50 Hz when `line_50hz` is 1 and 60 Hz when it is 0.
- R4: A start pulse (without clear) gives busy=1 and done=0 on the next cycle. If the timebase was idle, the first tick appears exactly one period after the start edge. If it was running, the tick phase is unchanged.
- R5: A clear pulse gives busy=0 and done=0 on the next cycle, and no tick appears until the next start.
- R6: The cycle after a tick, busy=0 and done=1 if busy was set. If busy was clear, the flags do not change and ticks continue. Done changes only on a tick, start or clear.
- R7: When start and clear are high in the same cycle, clear wins: busy=0, done=0 and the timebase stops.
- R8: `irq` equals done AND NOT `int_dis`. When `mask_ld` is high, `int_dis` takes `mask_bit` on the next cycle.
- R9: A rate write while running restarts the prescaler, so the next tick comes one full period of the new rate after the write edge.
- R10: After reset: `rate_sel`=0; busy, done, `int_dis`, `irq` and `tick` are 0; the timebase is stopped.
- R11: A start pulse in the same cycle as a tick wins over the tick: busy=1 and done=0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| dout_stb | input | 1 | Data-out strobe, loads the rate code |
| acc_in | input | ACC_W | Accumulator value; only bits [1:0] are used |
| start_pls | input | 1 | Start pulse |
| clear_pls | input | 1 | Clear pulse |
| mask_ld | input | 1 | Interrupt-disable load strobe |
| mask_bit | input | 1 | Interrupt-disable value loaded by `mask_ld` |
| line_50hz | input | 1 | Line rate for code 0: 1 = 50 Hz, 0 = 60 Hz |
| rate_sel | output | 2 | Current rate code |
| busy | output | 1 | Busy flag |
| done | output | 1 | Done flag |
| int_dis | output | 1 | Interrupt-disable mask |
| irq | output | 1 | Interrupt request |
| tick | output | 1 | One-cycle tick pulse from the timebase |

## Verification
The hardest cases to reach are the ones that depend on the tick phase. Examples are a start pulse landing exactly in the tick cycle, a restart while the timebase is running, and a rate write halfway through a period. The stimulus waits for an observed tick on the port and then fires the pulse in the following cycle or a fixed number of cycles later. That exact alignment is what the random phase rarely produces on its own. A long random phase with sparse strobes then mixes rate writes, masks and pulses against a cycle model kept in the bench.

// File: rtl/ic_pkg.sv
package ic_pkg;
  typedef enum logic [1:0] {
    RATE_LINE = 2'd0,
    RATE_10   = 2'd1,
    RATE_100  = 2'd2,
    RATE_1K   = 2'd3
  } rate_code_t;

  localparam int unsigned NUM_RATES = 5;   // four codes plus the 50 Hz line variant
  localparam int unsigned IDX_LINE50 = 4;

  function automatic int unsigned rate_hz(int unsigned idx);
    case (idx)
      0:       return 60;
      1:       return 10;
      2:       return 100;
      3:       return 1000;
      default: return 50;
    endcase
  endfunction
endpackage

// File: rtl/ic_rate_reg.sv
module ic_rate_reg #(
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [ACC_W-1:0] acc,
  output logic [1:0]       sel_q,
  output logic [1:0]       sel_eff
);
  // Code that applies at this edge: the new one when a write is present.
  assign sel_eff = wr ? acc[1:0] : sel_q;

  always_ff @(posedge clk) begin
    if (rst) sel_q <= 2'd0;
    else     sel_q <= sel_eff;
  end
endmodule

// File: rtl/ic_prescaler.sv
module ic_prescaler
  import ic_pkg::*;
#(
  parameter int unsigned SYS_HZ = 6000,
  parameter int unsigned CNT_W  = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       clear,
  input  logic       restart,
  input  logic [1:0] sel_eff,
  input  logic       line_50hz,
  output logic       tick_q
);
  logic [CNT_W-1:0] reload_tab [NUM_RATES];
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] reload;
  logic             run_q;

  for (genvar g = 0; g < NUM_RATES; g++) begin : g_reload
    localparam int unsigned RLD = SYS_HZ / rate_hz(g) - 1;
    assign reload_tab[g] = CNT_W'(RLD);
  end

  always_comb begin
    if (sel_eff == RATE_LINE && line_50hz) reload = reload_tab[IDX_LINE50];
    else                                   reload = reload_tab[sel_eff];
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (start && !run_q) begin
      run_q  <= 1'b1;
      cnt_q  <= reload;
      tick_q <= 1'b0;
    end else if (run_q && restart) begin
      cnt_q  <= reload;
      tick_q <= 1'b0;
    end else if (run_q && cnt_q == '0) begin
      cnt_q  <= reload;
      tick_q <= 1'b1;
    end else if (run_q) begin
      cnt_q  <= cnt_q - 1'b1;
      tick_q <= 1'b0;
    end else begin
      tick_q <= 1'b0;
    end
  end
endmodule

// File: rtl/ic_flags.sv
module ic_flags (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic clear,
  input  logic tick,
  input  logic mask_ld,
  input  logic mask_bit,
  output logic busy_q,
  output logic done_q,
  output logic mask_q,
  output logic irq_q
);
  logic busy_n, done_n, mask_n;

  always_comb begin
    busy_n = busy_q;
    done_n = done_q;
    if (clear) begin
      busy_n = 1'b0;
      done_n = 1'b0;
    end else if (start) begin
      busy_n = 1'b1;
      done_n = 1'b0;
    end else if (tick && busy_q) begin
      busy_n = 1'b0;
      done_n = 1'b1;
    end
    mask_n = mask_ld ? mask_bit : mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      mask_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      busy_q <= busy_n;
      done_q <= done_n;
      mask_q <= mask_n;
      irq_q  <= done_n & ~mask_n;
    end
  end
endmodule

// File: rtl/interval_clock.sv
module interval_clock #(
  parameter int unsigned SYS_HZ = 6000,
  parameter int          ACC_W  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dout_stb,
  input  logic [ACC_W-1:0] acc_in,
  input  logic             start_pls,
  input  logic             clear_pls,
  input  logic             mask_ld,
  input  logic             mask_bit,
  input  logic             line_50hz,
  output logic [1:0]       rate_sel,
  output logic             busy,
  output logic             done,
  output logic             int_dis,
  output logic             irq,
  output logic             tick
);
  localparam int unsigned CNT_W = $clog2(SYS_HZ / 10 + 1);

  logic [1:0] sel_eff;

  ic_rate_reg #(.ACC_W(ACC_W)) u_rate (
    .clk(clk), .rst(rst), .wr(dout_stb), .acc(acc_in),
    .sel_q(rate_sel), .sel_eff(sel_eff)
  );

  ic_prescaler #(.SYS_HZ(SYS_HZ), .CNT_W(CNT_W)) u_pre (
    .clk(clk), .rst(rst), .start(start_pls), .clear(clear_pls),
    .restart(dout_stb), .sel_eff(sel_eff), .line_50hz(line_50hz),
    .tick_q(tick)
  );

  ic_flags u_flags (
    .clk(clk), .rst(rst), .start(start_pls), .clear(clear_pls),
    .tick(tick), .mask_ld(mask_ld), .mask_bit(mask_bit),
    .busy_q(busy), .done_q(done), .mask_q(int_dis), .irq_q(irq)
  );
endmodule

// File: rtl/ic_checker.sv
module ic_checker (
  input logic       clk,
  input logic       rst,
  input logic       dout_stb,
  input logic [1:0] acc_lo,
  input logic       start_pls,
  input logic       clear_pls,
  input logic [1:0] rate_sel,
  input logic       busy,
  input logic       done,
  input logic       int_dis,
  input logic       irq,
  input logic       tick
);
  p_sel_load_r1: assert property (@(posedge clk) disable iff (rst)
    dout_stb |=> rate_sel == $past(acc_lo));

  p_tick_single_r2: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

  p_start_arms_r4: assert property (@(posedge clk) disable iff (rst)
    (start_pls && !clear_pls) |=> (busy && !done));

  p_clear_idles_r5: assert property (@(posedge clk) disable iff (rst)
    clear_pls |=> (!busy && !done && !tick));

  p_tick_done_r6: assert property (@(posedge clk) disable iff (rst)
    (tick && busy && !start_pls && !clear_pls) |=> (done && !busy));

  p_done_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!tick && !start_pls && !clear_pls) |=> $stable(done));

  p_clear_wins_r7: assert property (@(posedge clk) disable iff (rst)
    (start_pls && clear_pls) |=> !busy);

  p_irq_gate_r8: assert property (@(posedge clk) disable iff (rst)
    irq == (done && !int_dis));
endmodule

bind interval_clock ic_checker u_chk (
  .clk(clk), .rst(rst), .dout_stb(dout_stb), .acc_lo(acc_in[1:0]),
  .start_pls(start_pls), .clear_pls(clear_pls), .rate_sel(rate_sel),
  .busy(busy), .done(done), .int_dis(int_dis), .irq(irq), .tick(tick)
);

// File: tb/test_interval_clock.sv
module test_interval_clock;
  localparam int unsigned SYS_HZ = 6000;
  localparam int ACC_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dout_stb = 0, start_pls = 0, clear_pls = 0, mask_ld = 0, mask_bit = 0, line_50hz = 0;
  logic [ACC_W-1:0] acc_in = '0;
  logic [1:0] rate_sel;
  logic busy, done, int_dis, irq, tick;

  int checks = 0, fails = 0;

  // bench model state
  logic [1:0] m_sel;
  logic m_run, m_tick, m_busy, m_done, m_mask, m_irq;
  int   m_cnt;

  always #4 clk = ~clk;

  interval_clock #(.SYS_HZ(SYS_HZ), .ACC_W(ACC_W)) i_interval_clock (
    .clk(clk), .rst(rst), .dout_stb(dout_stb), .acc_in(acc_in),
    .start_pls(start_pls), .clear_pls(clear_pls), .mask_ld(mask_ld),
    .mask_bit(mask_bit), .line_50hz(line_50hz), .rate_sel(rate_sel),
    .busy(busy), .done(done), .int_dis(int_dis), .irq(irq), .tick(tick)
  );

  function automatic int period_of(logic [1:0] code, logic l50);
    case (code)
      2'd0:    return l50 ? SYS_HZ / 50 : SYS_HZ / 60;
      2'd1:    return SYS_HZ / 10;
      2'd2:    return SYS_HZ / 100;
      default: return SYS_HZ / 1000;
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    logic [1:0] eff;
    logic       tprev;
    if (rst) begin
      m_sel = 0; m_run = 0; m_cnt = 0; m_tick = 0;
      m_busy = 0; m_done = 0; m_mask = 0; m_irq = 0;
      return;
    end
    eff   = dout_stb ? acc_in[1:0] : m_sel;
    tprev = m_tick;
    if (clear_pls) begin m_run = 0; m_cnt = 0; m_tick = 0; end
    else if (start_pls && !m_run) begin m_run = 1; m_cnt = period_of(eff, line_50hz) - 1; m_tick = 0; end
    else if (m_run && dout_stb) begin m_cnt = period_of(eff, line_50hz) - 1; m_tick = 0; end
    else if (m_run && m_cnt == 0) begin m_cnt = period_of(eff, line_50hz) - 1; m_tick = 1; end
    else if (m_run) begin m_cnt--; m_tick = 0; end
    else m_tick = 0;
    if (clear_pls) begin m_busy = 0; m_done = 0; end
    else if (start_pls) begin m_busy = 1; m_done = 0; end
    else if (tprev && m_busy) begin m_busy = 0; m_done = 1; end
    if (mask_ld) m_mask = mask_bit;
    m_irq = m_done & ~m_mask;
    m_sel = eff;
  endtask

  task automatic compare();
    check("R1 rate_sel", rate_sel, m_sel);
    check("R2 tick", tick, m_tick);
    check("R6 busy", busy, m_busy);
    check("R6 done", done, m_done);
    check("R8 irq", irq, m_irq);
  endtask

  // one clock: inputs already driven; model follows the edge; compare at negedge
  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
    dout_stb = 0; start_pls = 0; clear_pls = 0; mask_ld = 0;
  endtask

  task automatic steps_until_tick(output int k);
    k = 0;
    do begin step(); k++; end while (!tick && k < 4000);
  endtask

  task automatic write_sel(logic [ACC_W-1:0] v);
    dout_stb = 1; acc_in = v; step();
  endtask

  task automatic measure(string req, logic [1:0] code, logic l50);
    int k;
    line_50hz = l50;
    clear_pls = 1; step();
    write_sel({$urandom_range(0, 16'h3FFF), code});
    start_pls = 1; step();
    steps_until_tick(k);
    check(req, k, period_of(code, l50));
    steps_until_tick(k);
    check(req, k, period_of(code, l50));
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int k;
    void'($urandom(32'd1234));
    rst = 1;
    step(); step(); step();
    rst = 0;
    step();
    // R10 reset state
    check("R10 sel", rate_sel, 0);
    check("R10 busy", busy, 0);
    check("R10 done", done, 0);
    check("R10 int_dis", int_dis, 0);
    check("R10 irq", irq, 0);
    repeat (20) step();
    check("R10 no tick while stopped", tick, 0);

    // R1 upper bits ignored
    write_sel(16'hFFF6);
    check("R1 low bits only", rate_sel, 2);

    // R2 / R3 periods
    measure("R2 rate 1000", 2'd3, 1'b0);
    measure("R2 rate 100", 2'd2, 1'b0);
    measure("R2 rate 10", 2'd1, 1'b0);
    measure("R3 line 60", 2'd0, 1'b0);
    measure("R3 line 50", 2'd0, 1'b1);
    check("R6 done after tick", done, 1);
    check("R6 busy after tick", busy, 0);

    // R4 phase unchanged on restart while running (rate 100, period 60)
    clear_pls = 1; step();
    write_sel(16'd2);
    start_pls = 1; step();
    steps_until_tick(k);
    repeat (3) step();
    start_pls = 1; step();
    check("R4 busy set", busy, 1);
    check("R4 done clear", done, 0);
    steps_until_tick(k);
    check("R4 phase kept", k, period_of(2, 0) - 4);

    // R11 start coincident with tick
    steps_until_tick(k);
    start_pls = 1; step();
    check("R11 busy", busy, 1);
    check("R11 done", done, 0);

    // R9 rate write mid-period restarts prescaler
    repeat (7) step();
    write_sel(16'd3);
    steps_until_tick(k);
    check("R9 new period", k, period_of(3, 0));

    // R8 mask gating
    steps_until_tick(k);
    step();
    check("R8 done", done, 1);
    mask_ld = 1; mask_bit = 1; step();
    check("R8 masked", irq, 0);
    mask_ld = 1; mask_bit = 0; step();
    check("R8 unmasked", irq, 1);

    // R5 clear stops timebase
    clear_pls = 1; step();
    check("R5 busy", busy, 0);
    check("R5 done", done, 0);
    k = 0;
    repeat (30) begin step(); if (tick) k++; end
    check("R5 no ticks", k, 0);

    // R7 start and clear together
    start_pls = 1; clear_pls = 1; step();
    check("R7 busy", busy, 0);
    k = 0;
    repeat (30) begin step(); if (tick) k++; end
    check("R7 stopped", k, 0);

    // random phase
    for (int i = 0; i < 6000; i++) begin
      dout_stb  = ($urandom_range(0, 99) < 2);
      acc_in    = ACC_W'($urandom);
      if (dout_stb && acc_in[1:0] == 2'd1 && $urandom_range(0, 3) != 0) acc_in[1:0] = 2'd3;
      start_pls = ($urandom_range(0, 99) < 3);
      clear_pls = ($urandom_range(0, 99) < 1);
      mask_ld   = ($urandom_range(0, 99) < 3);
      mask_bit  = $urandom_range(0, 1);
      if ($urandom_range(0, 499) == 0) line_50hz = ~line_50hz;
      step();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule